// File: doc/BRIEF.md
# Intersection Phase Controller

This block sequences the signals of a four-way crossing where a main artery carries no vehicle detector and a side road does. The artery rests on green. The side road, the side-road left turn and the artery left turn are served only when their demand flags ask for it. A train-present flag overrides the normal cycle and brings the controller back to the artery-green rest phase at the next point where it can safely do so.

Each phase is timed by counting pulses of a one-second tick input. The system clock only samples inputs and moves the state. Demand flags and the train flag are synchronous, already-debounced levels. The block drives the red/yellow/green lamps of both straight approaches and the yellow/green lamps of both left-turn signals. It also gives a one-cycle grant pulse when an approach is given its green, so that an outside vehicle counter can clear itself. It exposes its 4-bit phase code so that neighbouring logic can decode it.

Top module: `isect_phase_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, the phase becomes artery green (code 0000). The artery lamp shows green, the side-road lamp shows red, both left lamps are dark, and `grant` is zero.
- R2: Artery green is left only when `train` is low and the OR of the three demand flags has stayed high for 10 consecutive ticks counted within artery green. A shorter burst, or a wait while `train` is high, keeps the phase at artery green.
- R3: Both yellows (artery 0001, side road 0101) last exactly 2 ticks. Each is followed by its red phase (artery 0011, side road 0100), which keeps both straight approaches red for exactly 2 ticks. No straight green starts unless the cycle before showed red on both straight approaches.
- R4: When artery red (0011) ends, the next phase is chosen in priority order. Train high returns to artery green. Otherwise side-road left demand goes to side-road left green (0010). Otherwise the next phase is side-road green (0111).
- R5: Each left green (side road 0010, artery 1100) lasts exactly 10 ticks. Its left yellow (0110, 1101) follows and lasts exactly 2 ticks. Left signals have no red lamp.
- R6: After side-road left yellow, the next phase is side-road green if `train` is low, or artery green if it is high.
- R7: Side-road green lasts at least 10 ticks. After 10 ticks it ends as soon as either left-turn demand is high. It always ends at 24 ticks. A high `train` ends it on the next clock edge. It always ends into side-road yellow.
- R8: After side-road red, the next phase is artery left green if `art_left_req` is high and `train` is low; otherwise it is artery green. Artery left yellow always returns to artery green.
- R9: Lamp encodings are as follows. A straight lamp vector is {red,yellow,green}: green 001 in its green phase, yellow 010 in its yellow phase, red 100 in every other phase. A left lamp vector is {yellow,green} and is lit only in that left group's own green or yellow phase.
- R10: `grant` is high for exactly one cycle, in the first cycle of a newly entered green phase. Bit 0 is artery, bit 1 is side road, bit 2 is side-road left and bit 3 is artery left. At most one bit is ever set.
- R11: Phase durations count only ticks seen after the phase was entered. A tick on the entry edge is not counted, and without ticks no timed phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse per second |
| cross_req | input | 1 | Side-road straight demand level |
| cross_left_req | input | 1 | Side-road left-turn demand level |
| art_left_req | input | 1 | Artery left-turn demand level |
| train | input | 1 | Train present level |
| phase | output | 4 | Current phase code |
| art_lamp | output | 3 | Artery straight lamps {red,yellow,green} |
| crs_lamp | output | 3 | Side-road straight lamps {red,yellow,green} |
| art_left_lamp | output | 2 | Artery left lamps {yellow,green} |
| crs_left_lamp | output | 2 | Side-road left lamps {yellow,green} |
| grant | output | 4 | One-cycle green-granted pulses |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that demand and train levels are synchronous to `clk`. In particular, the counter checks assume that counts move only on tick cycles and that a phase is never left on the edge that entered it. The stimulus changes every input on falling clock edges. It raises `tick` for one cycle in every four, so a phase change never needs two ticks within one cycle. It also changes the train and demand flags at phase boundaries and mid-phase, to reach every decision branch.

// File: rtl/isect_pkg.sv
package isect_pkg;

   // Phase codes are fixed: neighbouring logic decodes them.
   typedef enum logic [3:0] {
      PH_ART_GO    = 4'b0000,
      PH_ART_AMBER = 4'b0001,
      PH_ART_STOP  = 4'b0011,
      PH_XL_GO     = 4'b0010,
      PH_XL_AMBER  = 4'b0110,
      PH_X_GO      = 4'b0111,
      PH_X_AMBER   = 4'b0101,
      PH_X_STOP    = 4'b0100,
      PH_AL_GO     = 4'b1100,
      PH_AL_AMBER  = 4'b1101
   } phase_e;

   localparam int unsigned NUM_APPROACH = 2;   // 0 artery, 1 side road
   localparam int unsigned STRAIGHT_W   = 3;   // {red,yellow,green}
   localparam int unsigned LEFT_W       = 2;   // {yellow,green}

endpackage

// File: rtl/isect_tick_timer.sv
module isect_tick_timer #(
   parameter int unsigned LIMIT = 24,
   parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] count
);

   initial begin : p_param_chk
      assert (LIMIT > 0 && (LIMIT < (1 << CW))) else $error("timer limit does not fit width");
   end

   // Up-counter of ticks, saturating at LIMIT, cleared on request.
   always_ff @(posedge clk) begin
      if (rst || clr)
         count <= '0;
      else if (tick && (count != CW'(LIMIT)))
         count <= count + 1'b1;
   end

   AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      !clr |=> count >= $past(count)) else $error("timer wrapped");          // R11

   AST_TMR_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
      (!tick && !clr) |=> $stable(count)) else $error("timer moved without tick"); // R11

endmodule

// File: rtl/isect_lamp_decode.sv
module isect_lamp_decode
   import isect_pkg::*;
(
   input  phase_e                                     ph,
   output logic [NUM_APPROACH-1:0][STRAIGHT_W-1:0]    straight,
   output logic [NUM_APPROACH-1:0][LEFT_W-1:0]        left
);

   // One identical decoder per approach, differing only in its phase codes.
   for (genvar a = 0; a < NUM_APPROACH; a++) begin : g_app
      localparam phase_e GO_PH  = (a == 0) ? PH_ART_GO    : PH_X_GO;
      localparam phase_e AMB_PH = (a == 0) ? PH_ART_AMBER : PH_X_AMBER;
      localparam phase_e LGO_PH = (a == 0) ? PH_AL_GO     : PH_XL_GO;
      localparam phase_e LAM_PH = (a == 0) ? PH_AL_AMBER  : PH_XL_AMBER;

      assign straight[a] = (ph == GO_PH)  ? 3'b001 :
                           (ph == AMB_PH) ? 3'b010 : 3'b100;
      assign left[a]     = {ph == LAM_PH, ph == LGO_PH};
   end

endmodule

// File: rtl/isect_phase_ctrl.sv
module isect_phase_ctrl
   import isect_pkg::*;
#(
   parameter int unsigned HOLD_TICKS  = 10,
   parameter int unsigned LEFT_TICKS  = 10,
   parameter int unsigned MIN_TICKS   = 10,
   parameter int unsigned MAX_TICKS   = 24,
   parameter int unsigned AMBER_TICKS = 2,
   parameter int unsigned CLEAR_TICKS = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       cross_req,
   input  logic       cross_left_req,
   input  logic       art_left_req,
   input  logic       train,
   output logic [3:0] phase,
   output logic [2:0] art_lamp,
   output logic [2:0] crs_lamp,
   output logic [1:0] art_left_lamp,
   output logic [1:0] crs_left_lamp,
   output logic [3:0] grant
);

   localparam int unsigned SPAN_G = (LEFT_TICKS > MAX_TICKS) ? LEFT_TICKS : MAX_TICKS;
   localparam int unsigned SPAN_S = (AMBER_TICKS > CLEAR_TICKS) ? AMBER_TICKS : CLEAR_TICKS;
   localparam int unsigned SPAN   = (SPAN_G > SPAN_S) ? SPAN_G : SPAN_S;
   localparam int unsigned TW     = $clog2(SPAN + 1);
   localparam int unsigned HW     = $clog2(HOLD_TICKS + 1);

   initial begin : p_param_chk
      assert (MIN_TICKS <= MAX_TICKS) else $error("minimum green exceeds maximum");
      assert (HOLD_TICKS > 0 && LEFT_TICKS > 0 && AMBER_TICKS > 0 && CLEAR_TICKS > 0)
         else $error("phase lengths must be non-zero");
   end

   phase_e          st_q, st_d;
   logic [TW-1:0]   el;
   logic [HW-1:0]   hold_cnt;
   logic            entering, any_req, held, hold_clr;
   logic            amber_done, clear_done, left_done, min_done, max_done;
   logic [NUM_APPROACH-1:0][STRAIGHT_W-1:0] str_l;
   logic [NUM_APPROACH-1:0][LEFT_W-1:0]     lft_l;

   assign entering   = (st_d != st_q);
   assign any_req    = cross_req | cross_left_req | art_left_req;
   assign hold_clr   = !any_req || (st_q != PH_ART_GO);
   assign held       = (hold_cnt == HW'(HOLD_TICKS));
   assign amber_done = (el >= TW'(AMBER_TICKS));
   assign clear_done = (el >= TW'(CLEAR_TICKS));
   assign left_done  = (el >= TW'(LEFT_TICKS));
   assign min_done   = (el >= TW'(MIN_TICKS));
   assign max_done   = (el >= TW'(MAX_TICKS));

   // Ticks spent in the current phase; restarts on every entry.
   isect_tick_timer #(.LIMIT(SPAN), .CW(TW)) u_phase_tmr (
      .clk(clk), .rst(rst), .clr(entering), .tick(tick), .count(el)
   );

   // Ticks of unbroken demand while resting on artery green.
   isect_tick_timer #(.LIMIT(HOLD_TICKS), .CW(HW)) u_hold_tmr (
      .clk(clk), .rst(rst), .clr(hold_clr), .tick(tick), .count(hold_cnt)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         PH_ART_GO:    if (!train && held) st_d = PH_ART_AMBER;
         PH_ART_AMBER: if (amber_done) st_d = PH_ART_STOP;
         PH_ART_STOP:  if (clear_done) begin
                          if (train)               st_d = PH_ART_GO;
                          else if (cross_left_req) st_d = PH_XL_GO;
                          else                     st_d = PH_X_GO;
                       end
         PH_XL_GO:     if (left_done) st_d = PH_XL_AMBER;
         PH_XL_AMBER:  if (amber_done) st_d = train ? PH_ART_GO : PH_X_GO;
         PH_X_GO:      if (train || max_done || (min_done && (cross_left_req || art_left_req)))
                          st_d = PH_X_AMBER;
         PH_X_AMBER:   if (amber_done) st_d = PH_X_STOP;
         PH_X_STOP:    if (clear_done) st_d = (art_left_req && !train) ? PH_AL_GO : PH_ART_GO;
         PH_AL_GO:     if (left_done) st_d = PH_AL_AMBER;
         PH_AL_AMBER:  if (amber_done) st_d = PH_ART_GO;
         default:      st_d = PH_ART_GO;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= PH_ART_GO;
         grant <= '0;
      end else begin
         st_q  <= st_d;
         grant <= entering ? {st_d == PH_AL_GO, st_d == PH_XL_GO, st_d == PH_X_GO, st_d == PH_ART_GO}
                           : 4'b0000;
      end
   end

   isect_lamp_decode u_lamps (.ph(st_q), .straight(str_l), .left(lft_l));

   assign phase         = st_q;
   assign art_lamp      = str_l[0];
   assign crs_lamp      = str_l[1];
   assign art_left_lamp = lft_l[0];
   assign crs_left_lamp = lft_l[1];

   AST_TRAIN_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
      (st_q == PH_ART_GO && train) |=> st_q == PH_ART_GO) else $error("left rest with train"); // R2

   AST_TRAIN_NO_LEFT: assert property (@(posedge clk) disable iff (rst)
      (st_q == PH_ART_STOP && train) |=> (st_q == PH_ART_STOP || st_q == PH_ART_GO))
      else $error("served side road during train");                                          // R4

   AST_CLEAR_BEFORE_XGO: assert property (@(posedge clk) disable iff (rst)
      $rose(crs_lamp[0]) |-> $past(art_lamp[2] && crs_lamp[2])) else $error("no all-red");   // R3

   AST_CLEAR_BEFORE_AGO: assert property (@(posedge clk) disable iff (rst)
      $rose(art_lamp[0]) |-> $past(art_lamp[2] && crs_lamp[2])) else $error("no all-red");   // R3

   AST_MIN_GREEN: assert property (@(posedge clk) disable iff (rst)
      (st_q == PH_X_GO && !train && entering) |-> min_done) else $error("short green");       // R7

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant)) else $error("several grants");                                        // R10

   AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
      (grant != 4'b0000) |=> (grant == 4'b0000)) else $error("grant longer than one cycle"); // R10

endmodule

// File: tb/sim_isect_phase_ctrl.sv
module sim_isect_phase_ctrl;

   localparam logic [3:0] AG = 4'b0000, AY = 4'b0001, AR = 4'b0011;
   localparam logic [3:0] XLG = 4'b0010, XLY = 4'b0110;
   localparam logic [3:0] XG = 4'b0111, XY = 4'b0101, XR = 4'b0100;
   localparam logic [3:0] ALG = 4'b1100, ALY = 4'b1101;

   typedef struct {
      logic [3:0] ph;
      int         ticks;
      string      req;
   } exp_t;

   logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
   logic cross_req = 1'b0, cross_left_req = 1'b0, art_left_req = 1'b0, train = 1'b0;
   logic [3:0] phase, grant;
   logic [2:0] art_lamp, crs_lamp;
   logic [1:0] art_left_lamp, crs_left_lamp;

   int   total = 0, bad = 0;
   bit   mon_on = 1'b0;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   isect_phase_ctrl u0 (
      .clk(clk), .rst(rst), .tick(tick), .cross_req(cross_req),
      .cross_left_req(cross_left_req), .art_left_req(art_left_req), .train(train),
      .phase(phase), .art_lamp(art_lamp), .crs_lamp(crs_lamp),
      .art_left_lamp(art_left_lamp), .crs_left_lamp(crs_left_lamp), .grant(grant)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // R9 lamp patterns: {art[2:0], crs[2:0], art_left[1:0], crs_left[1:0]}
   function automatic logic [9:0] exp_lamps(input logic [3:0] p);
      logic [2:0] a, c;
      a = (p == AG) ? 3'b001 : (p == AY) ? 3'b010 : 3'b100;
      c = (p == XG) ? 3'b001 : (p == XY) ? 3'b010 : 3'b100;
      return {a, c, {p == ALY, p == ALG}, {p == XLY, p == XLG}};
   endfunction

   // R10 grant bit per green phase
   function automatic logic [3:0] exp_grant(input logic [3:0] p);
      return (p == AG) ? 4'b0001 : (p == XG) ? 4'b0010 :
             (p == XLG) ? 4'b0100 : (p == ALG) ? 4'b1000 : 4'b0000;
   endfunction

   task automatic push(input logic [3:0] p, input int t, input string r);
      exp_t e;
      e.ph = p; e.ticks = t; e.req = r;
      exp_q.push_back(e);
   endtask

   task automatic wait_phase(input logic [3:0] p);
      @(negedge clk);
      while (phase != p) @(negedge clk);
   endtask

   task automatic drain(input string r);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(phase == AG, r, "rest phase after cycle", int'(phase), int'(AG));
   endtask

   // tick: one cycle high out of every four, changed on falling edges
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   // monitor: samples 5 ns after each rising edge
   initial begin
      logic [3:0] prev;
      int         cnt;
      exp_t       e;
      prev = AG;
      cnt  = 0;
      forever begin
         @(posedge clk);
         #5;
         if (mon_on) begin
            if (phase != prev) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R9", "unexpected phase change to", int'(phase), int'(prev));
               end else begin
                  e = exp_q.pop_front();
                  chk(e.ph == prev, e.req, "phase order", int'(prev), int'(e.ph));
                  if (e.ticks >= 0)
                     chk(cnt == e.ticks, {e.req, " R11"}, "ticks in phase", cnt, e.ticks);
               end
               chk({art_lamp, crs_lamp, art_left_lamp, crs_left_lamp} == exp_lamps(phase),
                   "R9", "lamps", int'({art_lamp, crs_lamp, art_left_lamp, crs_left_lamp}),
                   int'(exp_lamps(phase)));
               chk(grant == exp_grant(phase), "R10", "grant on entry", int'(grant),
                   int'(exp_grant(phase)));
               prev = phase;
               cnt  = 0;
            end else begin
               if (tick) cnt++;
               if (grant != 4'b0000)
                  chk(1'b0, "R10", "grant without entry", int'(grant), 0);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(phase == AG, "R1", "reset phase", int'(phase), int'(AG));
      chk({art_lamp, crs_lamp, art_left_lamp, crs_left_lamp} == 10'b001_100_00_00, "R1",
          "reset lamps", int'({art_lamp, crs_lamp, art_left_lamp, crs_left_lamp}), 10'b001_100_00_00);
      chk(grant == 4'b0000, "R1", "reset grant", int'(grant), 0);
      mon_on = 1'b1;

      // R2: a short demand burst does not leave rest
      cross_req = 1'b1;
      repeat (20) @(negedge clk);
      cross_req = 1'b0;
      repeat (60) @(negedge clk);
      chk(phase == AG, "R2", "short burst kept rest", int'(phase), int'(AG));

      // R2: held demand with train present keeps rest
      train = 1'b1;
      cross_req = 1'b1;
      repeat (60) @(negedge clk);
      chk(phase == AG, "R2", "train kept rest", int'(phase), int'(AG));

      // side road only: green runs to its 24-tick ceiling
      push(AG, -1, "R2"); push(AY, 2, "R3"); push(AR, 2, "R3");
      push(XG, 24, "R7"); push(XY, 2, "R3"); push(XR, 2, "R8");
      train = 1'b0;
      wait_phase(XG);
      cross_req = 1'b0;
      drain("R8");

      // all demands: left turns first, gap-out at 10, artery left served
      push(AG, -1, "R2"); push(AY, 2, "R3"); push(AR, 2, "R4");
      push(XLG, 10, "R5"); push(XLY, 2, "R6"); push(XG, 10, "R7");
      push(XY, 2, "R3"); push(XR, 2, "R8"); push(ALG, 10, "R5"); push(ALY, 2, "R8");
      cross_req = 1'b1; cross_left_req = 1'b1; art_left_req = 1'b1;
      wait_phase(XLG);
      cross_left_req = 1'b0;
      wait_phase(ALG);
      cross_req = 1'b0; art_left_req = 1'b0;
      drain("R8");

      // train during side-road green ends it at once and skips artery left
      push(AG, -1, "R2"); push(AY, 2, "R3"); push(AR, 2, "R4");
      push(XG, -1, "R7"); push(XY, 2, "R3"); push(XR, 2, "R8");
      cross_req = 1'b1; art_left_req = 1'b1;
      wait_phase(XG);
      repeat (8) @(negedge clk);
      train = 1'b1;
      @(negedge clk);
      chk(phase == XY, "R7", "train ends green", int'(phase), int'(XY));
      drain("R8");
      cross_req = 1'b0; art_left_req = 1'b0; train = 1'b0;

      // train during artery red returns to rest
      push(AG, -1, "R2"); push(AY, 2, "R3"); push(AR, 2, "R4");
      cross_left_req = 1'b1;
      wait_phase(AY);
      train = 1'b1;
      drain("R4");
      cross_left_req = 1'b0; train = 1'b0;

      // train during side-road left green: after its yellow go to rest
      push(AG, -1, "R2"); push(AY, 2, "R3"); push(AR, 2, "R4");
      push(XLG, 10, "R5"); push(XLY, 2, "R6");
      cross_left_req = 1'b1; cross_req = 1'b1;
      wait_phase(XLG);
      train = 1'b1;
      drain("R6");
      cross_left_req = 1'b0; cross_req = 1'b0; train = 1'b0;

      // artery left only: side-road green gaps out at its minimum
      push(AG, -1, "R2"); push(AY, 2, "R3"); push(AR, 2, "R4");
      push(XG, 10, "R7"); push(XY, 2, "R3"); push(XR, 2, "R8");
      push(ALG, 10, "R5"); push(ALY, 2, "R8");
      art_left_req = 1'b1;
      wait_phase(ALG);
      art_left_req = 1'b0;
      drain("R8");

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule